// File: doc/BRIEF.md
# Reloading 8-bit Timer with Tone Divider

This block is an up-counting timer/event counter. Each counting step adds one to an 8-bit count. When the count would pass its all-ones value, the block does three things. It loads the count from a preload register. It raises a sticky interrupt request. It toggles a divider output, so that output gives a square wave at half the overflow rate, which suits tone generation.

Counting steps come from one of two sources, chosen by a mode input. The first is an internal clock tick. The second is an external event line, which is synchronized by two flops and counted on its rising edge. While the counter runs, software can write a new preload value. That value waits in the preload register and reaches the count only at the next overflow. While the counter is stopped, a preload write also lands in the count directly.

Top module: `tone_timer8`

## Requirements
- R1: After reset the count is 0x00, the interrupt request is low and the divider output is low.
- R2: In internal mode (`src_ext_i`=0) with `run_i`=1, each cycle with `tick_i`=1 raises the count by one on the next clock edge, and a cycle with `tick_i`=0 leaves it unchanged.
- R3: With `run_i`=0 the count does not change on ticks or events; it changes only through a preload write.
- R4: A counting step taken while the count is 0xFF loads the count from the preload register (its value before that cycle's write) and sets `irq_o` on the same edge.
- R5: A preload write while `run_i`=1 leaves the live count untouched; the written value is loaded at the next overflow.
- R6: A preload write while `run_i`=0 places the written value in the count on the next edge.
- R7: `irq_o` stays high until a cycle with `irq_ack_i`=1 clears it. If an overflow occurs in the same cycle as an acknowledge, `irq_o` stays high.
- R8: With `div_en_i`=1, `div_o` toggles on every overflow. With `div_en_i`=0, `div_o` is low from the next edge on.
- R9: In external mode (`src_ext_i`=1), a rising edge on `evt_i` adds exactly one to the count, on the third clock edge after the rise. `tick_i` is ignored in this mode, and `evt_i` is ignored in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Internal count strobe |
| evt_i | input | 1 | Asynchronous external event line |
| run_i | input | 1 | Counter enable |
| src_ext_i | input | 1 | Count source: 0 tick, 1 external event |
| pre_we_i | input | 1 | Preload write strobe |
| pre_data_i | input | 8 | Preload write data |
| irq_ack_i | input | 1 | Clears the interrupt request |
| div_en_i | input | 1 | Divider output enable |
| irq_o | output | 1 | Sticky overflow interrupt request |
| div_o | output | 1 | Divider square-wave output |
| count_o | output | 8 | Live count value |

## Verification
A tick, an overflow, a preload write and an acknowledge each show up at the outputs one clock edge after the cycle in which they are presented. An external event shows up in the count three edges after `evt_i` rises. The bench drives its inputs 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge, so a check always sees the register state that the previous cycle's stimulus produced. For the event path, the bench model carries its own three-stage delay, so the random phase expects each edge in the cycle where it is due.

// File: rtl/tone_timer8.sv
module tone_timer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         evt_i,
  input  logic         run_i,
  input  logic         src_ext_i,
  input  logic         pre_we_i,
  input  logic [W-1:0] pre_data_i,
  input  logic         irq_ack_i,
  input  logic         div_en_i,
  output logic         irq_o,
  output logic         div_o,
  output logic [W-1:0] count_o
);

  logic [W-1:0] cnt, pre;
  logic [2:0]   sy;

  wire ev_rise = sy[1] & ~sy[2];
  wire step    = run_i & (src_ext_i ? ev_rise : tick_i);
  wire wrap    = step & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pre   <= '0;
      sy    <= '0;
      irq_o <= 1'b0;
      div_o <= 1'b0;
    end else begin
      sy <= {sy[1:0], evt_i};
      if (pre_we_i) pre <= pre_data_i;

      if (wrap)                   cnt <= pre;
      else if (step)              cnt <= cnt + W'(1);
      else if (pre_we_i && !run_i) cnt <= pre_data_i;

      if (wrap)           irq_o <= 1'b1;
      else if (irq_ack_i) irq_o <= 1'b0;

      if (!div_en_i)  div_o <= 1'b0;
      else if (wrap)  div_o <= ~div_o;
    end
  end

  assign count_o = cnt;

endmodule

// File: rtl/tone_timer8_chk.sv
module tone_timer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         run_i,
  input logic         src_ext_i,
  input logic         pre_we_i,
  input logic         irq_ack_i,
  input logic         div_en_i,
  input logic         irq_o,
  input logic         div_o,
  input logic [W-1:0] count_o
);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !src_ext_i && tick_i && !(&count_o)) |=> count_o == $past(count_o) + W'(1));

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !src_ext_i && !tick_i) |=> $stable(count_o));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !pre_we_i) |=> $stable(count_o));

  a_r4_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !src_ext_i && tick_i && (&count_o)) |=> irq_o);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack_i) |=> irq_o);

  a_r8_div_low: assert property (@(posedge clk) disable iff (!rst_n)
    !div_en_i |=> !div_o);

  a_r8_div_still: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en_i && !irq_o && $stable(irq_o) && !run_i) |=> $stable(div_o));

endmodule

bind tone_timer8 tone_timer8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
  .src_ext_i(src_ext_i), .pre_we_i(pre_we_i), .irq_ack_i(irq_ack_i),
  .div_en_i(div_en_i), .irq_o(irq_o), .div_o(div_o), .count_o(count_o)
);

// File: tb/tb_tone_timer8.sv
`timescale 1ns/1ps
module tb_tone_timer8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tick_i, evt_i, run_i, src_ext_i, pre_we_i, irq_ack_i, div_en_i;
  logic [7:0] pre_data_i;
  logic irq_o, div_o;
  logic [7:0] count_o;

  tone_timer8 dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .evt_i(evt_i), .run_i(run_i),
    .src_ext_i(src_ext_i), .pre_we_i(pre_we_i), .pre_data_i(pre_data_i),
    .irq_ack_i(irq_ack_i), .div_en_i(div_en_i), .irq_o(irq_o), .div_o(div_o),
    .count_o(count_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] m_cnt, m_pre;
  logic [2:0] m_sy;
  logic m_irq, m_div;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic ext_rise(input logic [2:0] s);
    return s[1] & ~s[2];
  endfunction

  // Reference model built from the requirements; evaluated once per clock.
  task automatic model_step();
    logic st, wr;
    st = run_i & (src_ext_i ? ext_rise(m_sy) : tick_i);
    wr = st & (m_cnt == 8'hFF);
    if (wr)                      m_cnt = m_pre;
    else if (st)                 m_cnt = m_cnt + 8'd1;
    else if (pre_we_i && !run_i) m_cnt = pre_data_i;
    if (pre_we_i) m_pre = pre_data_i;
    if (wr)             m_irq = 1'b1;
    else if (irq_ack_i) m_irq = 1'b0;
    if (!div_en_i) m_div = 1'b0;
    else if (wr)   m_div = ~m_div;
    m_sy = {m_sy[1:0], evt_i};
  endtask

  task automatic cyc();
    if (rst_n) model_step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    tick_i = 0; evt_i = 0; run_i = 0; src_ext_i = 0; pre_we_i = 0;
    pre_data_i = 0; irq_ack_i = 0; div_en_i = 1;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_in();
    rst_n = 0;
    m_cnt = 0; m_pre = 0; m_sy = 0; m_irq = 0; m_div = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    chk("R1 count", count_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 div", div_o, 0);

    // R6: stopped preload write lands in count
    pre_we_i = 1; pre_data_i = 8'hFC; cyc(); pre_we_i = 0;
    chk("R6 stopped load", count_o, 8'hFC);

    // R2: internal ticks
    run_i = 1; tick_i = 1; cyc();
    chk("R2 tick", count_o, 8'hFD);
    // R5: running write does not touch count
    pre_we_i = 1; pre_data_i = 8'h10; cyc(); pre_we_i = 0;
    chk("R5 count untouched", count_o, 8'hFE);
    cyc();
    chk("R2 tick to FF", count_o, 8'hFF);
    cyc();
    chk("R4 reload value", count_o, 8'h10);
    chk("R4 irq set", irq_o, 1);
    chk("R8 div toggled", div_o, 1);
    tick_i = 0; cyc();
    chk("R2 no tick holds", count_o, 8'h10);
    chk("R7 irq sticky", irq_o, 1);
    irq_ack_i = 1; cyc(); irq_ack_i = 0;
    chk("R7 ack clears", irq_o, 0);

    // R3: stopped counter ignores ticks and events
    run_i = 0; tick_i = 1; evt_i = 1; repeat (4) cyc();
    chk("R3 hold", count_o, 8'h10);
    evt_i = 0; tick_i = 0; repeat (3) cyc();

    // R7: overflow with acknowledge in the same cycle
    pre_we_i = 1; pre_data_i = 8'hFF; cyc(); pre_we_i = 0;
    chk("R6 load FF", count_o, 8'hFF);
    run_i = 1; tick_i = 1; irq_ack_i = 1; cyc(); irq_ack_i = 0; tick_i = 0;
    chk("R7 overflow beats ack", irq_o, 1);
    chk("R4 reload FF", count_o, 8'hFF);
    chk("R8 div second toggle", div_o, 0);
    tick_i = 1; cyc(); tick_i = 0;
    chk("R8 div third toggle", div_o, 1);
    div_en_i = 0; cyc();
    chk("R8 div held low", div_o, 0);
    div_en_i = 1; irq_ack_i = 1; cyc(); irq_ack_i = 0;

    // R9: external event counting
    run_i = 0; pre_we_i = 1; pre_data_i = 8'h20; cyc(); pre_we_i = 0;
    run_i = 1; src_ext_i = 1; tick_i = 1; repeat (3) cyc();
    chk("R9 tick ignored in ext mode", count_o, 8'h20);
    evt_i = 1; cyc(); cyc();
    chk("R9 not yet counted", count_o, 8'h20);
    cyc();
    chk("R9 counted on third edge", count_o, 8'h21);
    repeat (4) cyc();
    chk("R9 counted once", count_o, 8'h21);
    src_ext_i = 0; tick_i = 0;
    for (int k = 0; k < 6; k++) begin evt_i = ~evt_i; cyc(); end
    chk("R9 evt ignored in internal mode", count_o, 8'h21);
    evt_i = 0; repeat (3) cyc();

    // Random phase against the bench model
    for (int n = 0; n < 4000; n++) begin
      run_i      = ($urandom % 8) != 0;
      tick_i     = ($urandom % 2) != 0;
      evt_i      = ($urandom % 3) == 0;
      if (($urandom % 50) == 0) src_ext_i = ~src_ext_i;
      pre_we_i   = ($urandom % 20) == 0;
      pre_data_i = 8'($urandom % 8) + 8'hF8 - (($urandom % 2) != 0 ? 8'h40 : 8'h00);
      irq_ack_i  = ($urandom % 10) == 0;
      div_en_i   = ($urandom % 16) != 0;
      cyc();
      chk("R2 R4 R5 R9 model count", count_o, m_cnt);
      chk("R7 model irq", irq_o, m_irq);
      chk("R8 model div", div_o, m_div);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule